// File: doc/BRIEF.md
# Serial TDM Port Loopback and Clock Pin Controller

This block sits at the edge of a time-division-multiplexed serial port. On one side are the serial receive and transmit pins. Inside are a byte-wide receive shifter, a byte-wide transmit shifter and a store register that writes into two parallel memory channels: a switching channel and a buffer channel. One 32-bit configuration word, written through a simple write strobe, does three things:
- it selects any mix of five loopback points;
- it gates the telecom clock that feeds the rest of the port;
- it chooses what drives three clock output pins.

Serial bits advance on cycles of the system clock where the bit strobe `bit_tick` is high and the telecom clock gate is open. Bits are received and sent most significant bit first. The clock sources (local generator, external slave clock, raw oscillator, two recovered clocks) arrive as inputs. The block only gates and steers them, so the clock outputs are combinational functions of those inputs and of the configuration.

The memories are outside the block. For each channel the block sees the read data, and drives the write data and a one-cycle write enable.

Top module: `tdm_loopback_ctrl`

## Requirements
- R1: After reset the configuration is all zero. `tel_clk`, `clk_out_a`, `clk_out_b` and `clk_out_c` are 0, `ser_tx_pin` is 0, and neither channel write enable is high.
- R2: While configuration bit 31 is set, `ser_tx_pin` equals `ser_rx_pin` in the same cycle.
- R3: While bit 30 is set, the receive shifter takes its bits from the value on `ser_tx_pin` and ignores `ser_rx_pin`.
- R4: While bit 29 is set, the transmit shifter loads each received byte at the moment that byte completes. `ser_tx_pin` then replays the receive stream delayed by exactly one byte (8 bit ticks).
- R5: Bit 31 takes priority over bit 29: with both set, `ser_tx_pin` follows `ser_rx_pin` directly.
- R6: While bit 28 is set, on each completed byte the store register loads the read data of the channel chosen by `store_sel` (0 = switching, 1 = buffer) instead of the received byte. That channel's write enable then pulses alone.
- R7: While bit 27 is set, `swc_wr_data` equals `swc_rd_data` and `bfc_wr_data` equals `bfc_rd_data`.
- R8: Bit 26 gates `tel_clk`. When it is 0, `tel_clk` is 0. When it is 1, `tel_clk` follows `slave_clk` if `clk_src_slave` is 1, and `gen_clk` otherwise.
- R9: Bits 25:24 select the outputs of pins b and c:
  - 00: both 0.
  - 01: b = `tel_clk`, c = 0.
  - 10: b = `tel_clk`, c = inverse of `tel_clk`.
  - 11: b = `tel_clk`, c = `osc_clk`.
- R10: Bits 23:22 select `clk_out_a`: 10 gives `pll_rec_clk`, 11 gives `syn_rec_clk`, and 00 or 01 give 0.
- R11: Every eighth accepted tick completes a byte, received MSB first. In the cycle after that tick, `rx_stb` is high and `rx_byte` holds the byte. With bit 28 clear, the received byte is written to the channel chosen by `store_sel` in that same cycle. With bit 29 clear, `tx_byte` is loaded for transmission MSB first.
- R12: Bit ticks that arrive while bit 26 is clear are ignored: no byte completes, and the bit count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| gen_clk | input | 1 | Locally generated telecom clock |
| slave_clk | input | 1 | External slave clock |
| clk_src_slave | input | 1 | 1 selects slave_clk as the telecom clock source |
| osc_clk | input | 1 | Raw internal oscillator clock |
| pll_rec_clk | input | 1 | Recovered clock from second PLL |
| syn_rec_clk | input | 1 | Recovered clock from synthesizer |
| tel_clk | output | 1 | Gated telecom clock |
| clk_out_a | output | 1 | Recovered clock pin |
| clk_out_b | output | 1 | Telecom clock pin |
| clk_out_c | output | 1 | Auxiliary clock pin |
| bit_tick | input | 1 | Serial bit strobe |
| ser_rx_pin | input | 1 | Serial receive pin |
| ser_tx_pin | output | 1 | Serial transmit pin |
| tx_byte | input | 8 | Byte to transmit next |
| rx_byte | output | 8 | Last completed received byte |
| rx_stb | output | 1 | One-cycle pulse with a new rx_byte |
| store_sel | input | 1 | Store target: 0 switching, 1 buffer |
| swc_rd_data | input | 8 | Switching channel read data |
| swc_wr_data | output | 8 | Switching channel write data |
| swc_wr_en | output | 1 | Switching channel write enable |
| bfc_rd_data | input | 8 | Buffer channel read data |
| bfc_wr_data | output | 8 | Buffer channel write data |
| bfc_wr_en | output | 1 | Buffer channel write enable |

## Verification
Assertions check the combinational rules on every cycle:
- the pin loopback and the receive-source loopback;
- the parallel write-back path;
- the clock gate;
- the off states of the three clock pins;
- that at most one write enable is high;
- that no byte completes while the gate is shut.

Only the bench scenarios can show the properties that span a whole byte:
- the exact one-byte replay delay;
- MSB-first framing;
- which channel receives the store data and with what value;
- the priority of the pin loopback over the byte loopback;
- that ignored ticks leave the bit count untouched.

// File: rtl/tdm_lb_pkg.sv
package tdm_lb_pkg;

   localparam int CFG_W = 32;

   // configuration bit positions
   localparam int B_PIN_LOOP   = 31;
   localparam int B_RX_FROM_TX = 30;
   localparam int B_BYTE_LOOP  = 29;
   localparam int B_STORE_LOOP = 28;
   localparam int B_PAR_LOOP   = 27;
   localparam int B_CLK_EN     = 26;
   localparam int F_PBC_HI     = 25;
   localparam int F_PBC_LO     = 24;
   localparam int F_PA_HI      = 23;
   localparam int F_PA_LO      = 22;

   typedef enum logic [1:0] {
      PBC_OFF  = 2'b00,
      PBC_TEL  = 2'b01,
      PBC_DIFF = 2'b10,
      PBC_OSC  = 2'b11
   } pin_bc_mode_e;

   typedef enum logic [1:0] {
      PA_OFF0 = 2'b00,
      PA_OFF1 = 2'b01,
      PA_PLL  = 2'b10,
      PA_SYN  = 2'b11
   } pin_a_mode_e;

   typedef struct packed {
      logic         pin_loop;
      logic         rx_from_tx;
      logic         byte_loop;
      logic         store_loop;
      logic         par_loop;
      logic         clk_en;
      pin_bc_mode_e pbc;
      pin_a_mode_e  pa;
   } tdm_ctl_t;

   localparam int CTL_W = $bits(tdm_ctl_t);

   function automatic tdm_ctl_t decode_cfg(input logic [CFG_W-1:0] w);
      tdm_ctl_t c;
      c.pin_loop   = w[B_PIN_LOOP];
      c.rx_from_tx = w[B_RX_FROM_TX];
      c.byte_loop  = w[B_BYTE_LOOP];
      c.store_loop = w[B_STORE_LOOP];
      c.par_loop   = w[B_PAR_LOOP];
      c.clk_en     = w[B_CLK_EN];
      c.pbc        = pin_bc_mode_e'(w[F_PBC_HI:F_PBC_LO]);
      c.pa         = pin_a_mode_e'(w[F_PA_HI:F_PA_LO]);
      return c;
   endfunction

endpackage

// File: rtl/tdm_cfg_reg.sv
module tdm_cfg_reg
   import tdm_lb_pkg::*;
#(
   parameter int WORD_W = CFG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   output tdm_ctl_t          ctl
);
   localparam int LOW_UNUSED = F_PA_LO;

   generate
      if (WORD_W != CFG_W) begin : g_bad_width
         $error("tdm_cfg_reg: WORD_W must equal CFG_W");
      end
   endgenerate

   logic unused_low_bits;
   assign unused_low_bits = ^wdata[LOW_UNUSED-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (we) begin
         ctl <= decode_cfg(wdata);
      end
   end
endmodule

// File: rtl/tdm_clk_sel.sv
module tdm_clk_sel
   import tdm_lb_pkg::*;
(
   input  tdm_ctl_t ctl,
   input  logic     gen_clk,
   input  logic     slave_clk,
   input  logic     src_slave,
   input  logic     osc_clk,
   input  logic     pll_clk,
   input  logic     syn_clk,
   output logic     tel_clk,
   output logic     pin_a,
   output logic     pin_b,
   output logic     pin_c
);
   logic src_clk;

   always_comb begin
      src_clk = src_slave ? slave_clk : gen_clk;
      tel_clk = ctl.clk_en & src_clk;
   end

   always_comb begin
      unique case (ctl.pbc)
         PBC_OFF:  begin pin_b = 1'b0;    pin_c = 1'b0;     end
         PBC_TEL:  begin pin_b = tel_clk; pin_c = 1'b0;     end
         PBC_DIFF: begin pin_b = tel_clk; pin_c = ~tel_clk; end
         default:  begin pin_b = tel_clk; pin_c = osc_clk;  end
      endcase
   end

   always_comb begin
      unique case (ctl.pa)
         PA_PLL:  pin_a = pll_clk;
         PA_SYN:  pin_a = syn_clk;
         default: pin_a = 1'b0;
      endcase
   end
endmodule

// File: rtl/tdm_serdes.sv
module tdm_serdes #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              rx_bit,
   input  logic              byte_loop,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              tx_msb,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_now,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_stb
);
   localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("tdm_serdes: BYTE_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] sin_q;
   logic [BYTE_W-1:0] sout_q;

   assign byte_now  = {sin_q[BYTE_W-2:0], rx_bit};
   assign byte_done = tick_en && (bit_cnt == LAST_IDX);
   assign tx_msb    = sout_q[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         sin_q   <= '0;
         sout_q  <= '0;
         rx_byte <= '0;
         rx_stb  <= 1'b0;
      end else begin
         rx_stb <= byte_done;
         if (tick_en) begin
            sin_q <= byte_now;
            if (byte_done) begin
               bit_cnt <= '0;
               rx_byte <= byte_now;
               sout_q  <= byte_loop ? byte_now : tx_byte;
            end else begin
               bit_cnt <= bit_cnt + CNT_W'(1);
               sout_q  <= {sout_q[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/tdm_store_path.sv
module tdm_store_path #(
   parameter int BYTE_W = 8,
   parameter int N_CH   = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  byte_done,
   input  logic [BYTE_W-1:0]     new_byte,
   input  logic                  store_loop,
   input  logic                  par_loop,
   input  logic [SEL_W-1:0]      sel,
   input  logic [BYTE_W-1:0]     rd_data [N_CH],
   output logic [BYTE_W-1:0]     wr_data [N_CH],
   output logic [N_CH-1:0]       wr_en
);
   localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1;

   generate
      if (N_CH < 2) begin : g_bad_ch
         $error("tdm_store_path: N_CH must be at least 2");
      end
   endgenerate

   logic [BYTE_W-1:0] store_q;
   logic [SEL_W-1:0]  tgt_q;
   logic              wr_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
         tgt_q   <= '0;
         wr_stb  <= 1'b0;
      end else begin
         wr_stb <= byte_done;
         if (byte_done) begin
            store_q <= store_loop ? rd_data[sel] : new_byte;
            tgt_q   <= sel;
         end
      end
   end

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         assign wr_en[c]   = wr_stb && (tgt_q == SEL_W'(c));
         assign wr_data[c] = par_loop ? rd_data[c] : store_q;
      end
   endgenerate
endmodule

// File: rtl/tdm_loopback_ctrl.sv
module tdm_loopback_ctrl
   import tdm_lb_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [31:0]       cfg_wdata,
   input  logic              gen_clk,
   input  logic              slave_clk,
   input  logic              clk_src_slave,
   input  logic              osc_clk,
   input  logic              pll_rec_clk,
   input  logic              syn_rec_clk,
   output logic              tel_clk,
   output logic              clk_out_a,
   output logic              clk_out_b,
   output logic              clk_out_c,
   input  logic              bit_tick,
   input  logic              ser_rx_pin,
   output logic              ser_tx_pin,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_stb,
   input  logic              store_sel,
   input  logic [BYTE_W-1:0] swc_rd_data,
   output logic [BYTE_W-1:0] swc_wr_data,
   output logic              swc_wr_en,
   input  logic [BYTE_W-1:0] bfc_rd_data,
   output logic [BYTE_W-1:0] bfc_wr_data,
   output logic              bfc_wr_en
);
   localparam int N_CH   = 2;
   localparam int CH_SW  = 0;
   localparam int CH_BUF = 1;

   tdm_ctl_t          ctl;
   logic              tick_en;
   logic              rx_serial;
   logic              tx_msb;
   logic              byte_done;
   logic [BYTE_W-1:0] byte_now;
   logic [BYTE_W-1:0] rd_arr [N_CH];
   logic [BYTE_W-1:0] wr_arr [N_CH];
   logic [N_CH-1:0]   we_vec;

   tdm_cfg_reg #(.WORD_W(CFG_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .ctl   (ctl)
   );

   tdm_clk_sel u_clk (
      .ctl       (ctl),
      .gen_clk   (gen_clk),
      .slave_clk (slave_clk),
      .src_slave (clk_src_slave),
      .osc_clk   (osc_clk),
      .pll_clk   (pll_rec_clk),
      .syn_clk   (syn_rec_clk),
      .tel_clk   (tel_clk),
      .pin_a     (clk_out_a),
      .pin_b     (clk_out_b),
      .pin_c     (clk_out_c)
   );

   // pin loopback wins over the shifter output
   assign tick_en    = bit_tick & ctl.clk_en;
   assign ser_tx_pin = ctl.pin_loop ? ser_rx_pin : tx_msb;
   assign rx_serial  = ctl.rx_from_tx ? ser_tx_pin : ser_rx_pin;

   tdm_serdes #(.BYTE_W(BYTE_W)) u_serdes (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .rx_bit    (rx_serial),
      .byte_loop (ctl.byte_loop),
      .tx_byte   (tx_byte),
      .tx_msb    (tx_msb),
      .byte_done (byte_done),
      .byte_now  (byte_now),
      .rx_byte   (rx_byte),
      .rx_stb    (rx_stb)
   );

   assign rd_arr[CH_SW]  = swc_rd_data;
   assign rd_arr[CH_BUF] = bfc_rd_data;

   tdm_store_path #(.BYTE_W(BYTE_W), .N_CH(N_CH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_done  (byte_done),
      .new_byte   (byte_now),
      .store_loop (ctl.store_loop),
      .par_loop   (ctl.par_loop),
      .sel        (store_sel),
      .rd_data    (rd_arr),
      .wr_data    (wr_arr),
      .wr_en      (we_vec)
   );

   assign swc_wr_data = wr_arr[CH_SW];
   assign bfc_wr_data = wr_arr[CH_BUF];
   assign swc_wr_en   = we_vec[CH_SW];
   assign bfc_wr_en   = we_vec[CH_BUF];
endmodule

// File: rtl/tdm_loopback_ctrl_chk.sv
module tdm_loopback_ctrl_chk
   import tdm_lb_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input tdm_ctl_t          ctl,
   input logic              ser_rx_pin,
   input logic              ser_tx_pin,
   input logic              rx_serial,
   input logic              tel_clk,
   input logic              clk_out_a,
   input logic              clk_out_b,
   input logic              clk_out_c,
   input logic [BYTE_W-1:0] swc_rd_data,
   input logic [BYTE_W-1:0] swc_wr_data,
   input logic [BYTE_W-1:0] bfc_rd_data,
   input logic [BYTE_W-1:0] bfc_wr_data,
   input logic              swc_wr_en,
   input logic              bfc_wr_en,
   input logic              rx_stb
);
   assert_pin_loop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.pin_loop |-> (ser_tx_pin == ser_rx_pin));

   assert_rx_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.rx_from_tx |-> (rx_serial == ser_tx_pin));

   assert_one_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({swc_wr_en, bfc_wr_en}));

   assert_par_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.par_loop |-> (swc_wr_data == swc_rd_data && bfc_wr_data == bfc_rd_data));

   assert_clk_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.clk_en |-> !tel_clk);

   assert_pins_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.pbc == PBC_OFF) |-> (!clk_out_b && !clk_out_c));

   assert_pin_b_tel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.pbc != PBC_OFF) |-> (clk_out_b == tel_clk));

   assert_pin_a_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.pa == PA_OFF0 || ctl.pa == PA_OFF1) |-> !clk_out_a);

   assert_no_byte_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.clk_en |=> !rx_stb);
endmodule

bind tdm_loopback_ctrl tdm_loopback_ctrl_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl         (ctl),
   .ser_rx_pin  (ser_rx_pin),
   .ser_tx_pin  (ser_tx_pin),
   .rx_serial   (rx_serial),
   .tel_clk     (tel_clk),
   .clk_out_a   (clk_out_a),
   .clk_out_b   (clk_out_b),
   .clk_out_c   (clk_out_c),
   .swc_rd_data (swc_rd_data),
   .swc_wr_data (swc_wr_data),
   .bfc_rd_data (bfc_rd_data),
   .bfc_wr_data (bfc_wr_data),
   .swc_wr_en   (swc_wr_en),
   .bfc_wr_en   (bfc_wr_en),
   .rx_stb      (rx_stb)
);

// File: tb/tdm_loopback_ctrl_test.sv
module tdm_loopback_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int BW = 8;

   localparam logic [31:0] C_PIN   = 32'h8000_0000;
   localparam logic [31:0] C_RXTX  = 32'h4000_0000;
   localparam logic [31:0] C_BYTE  = 32'h2000_0000;
   localparam logic [31:0] C_STORE = 32'h1000_0000;
   localparam logic [31:0] C_PAR   = 32'h0800_0000;
   localparam logic [31:0] C_EN    = 32'h0400_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic gen_clk = 1'b0, slave_clk = 1'b0, clk_src_slave = 1'b0;
   logic osc_clk = 1'b0, pll_rec_clk = 1'b0, syn_rec_clk = 1'b0;
   logic tel_clk, clk_out_a, clk_out_b, clk_out_c;
   logic bit_tick = 1'b0, ser_rx_pin = 1'b0, ser_tx_pin;
   logic [BW-1:0] tx_byte = '0, rx_byte;
   logic rx_stb;
   logic store_sel = 1'b0;
   logic [BW-1:0] swc_rd_data = '0, swc_wr_data, bfc_rd_data = '0, bfc_wr_data;
   logic swc_wr_en, bfc_wr_en;

   int n_run = 0;
   int n_fail = 0;
   logic [BW-1:0] tx_cap = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tdm_loopback_ctrl #(.BYTE_W(BW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .gen_clk(gen_clk), .slave_clk(slave_clk), .clk_src_slave(clk_src_slave),
      .osc_clk(osc_clk), .pll_rec_clk(pll_rec_clk), .syn_rec_clk(syn_rec_clk),
      .tel_clk(tel_clk), .clk_out_a(clk_out_a), .clk_out_b(clk_out_b), .clk_out_c(clk_out_c),
      .bit_tick(bit_tick), .ser_rx_pin(ser_rx_pin), .ser_tx_pin(ser_tx_pin),
      .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_stb(rx_stb), .store_sel(store_sel),
      .swc_rd_data(swc_rd_data), .swc_wr_data(swc_wr_data), .swc_wr_en(swc_wr_en),
      .bfc_rd_data(bfc_rd_data), .bfc_wr_data(bfc_wr_data), .bfc_wr_en(bfc_wr_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bit_tick = 1'b0; cfg_we = 1'b0; ser_rx_pin = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_cfg(input logic [31:0] w);
      cfg_we = 1'b1; cfg_wdata = w;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      ser_rx_pin = b; bit_tick = 1'b1;
      #1;
      tx_cap = {tx_cap[BW-2:0], ser_tx_pin};
      @(posedge clk);
      @(negedge clk);
      bit_tick = 1'b0;
   endtask

   task automatic send_byte(input logic [BW-1:0] v);
      for (int i = BW - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic t_reset();
      gen_clk = 1'b1; slave_clk = 1'b1; osc_clk = 1'b1; pll_rec_clk = 1'b1; syn_rec_clk = 1'b1;
      do_reset();
      #1;
      check("R1 tel_clk", tel_clk, 0);
      check("R1 clock pins", {clk_out_a, clk_out_b, clk_out_c}, 0);
      check("R1 tx pin", ser_tx_pin, 0);
      check("R1 write enables", {swc_wr_en, bfc_wr_en}, 0);
   endtask

   task automatic t_gate();
      do_reset();
      gen_clk = 1'b1; slave_clk = 1'b0; clk_src_slave = 1'b0;
      #1; check("R8 gated", tel_clk, 0);
      wr_cfg(C_EN); #1;
      check("R8 gen source", tel_clk, 1);
      clk_src_slave = 1'b1; #1;
      check("R8 slave low", tel_clk, 0);
      slave_clk = 1'b1; #1;
      check("R8 slave high", tel_clk, 1);
      clk_src_slave = 1'b0;
   endtask

   task automatic t_pin_bc();
      do_reset();
      gen_clk = 1'b1; osc_clk = 1'b0;
      wr_cfg(C_EN | 32'h0100_0000); #1;
      check("R9 code01", {clk_out_b, clk_out_c}, 2'b10);
      wr_cfg(C_EN | 32'h0200_0000); #1;
      check("R9 code10 high", {clk_out_b, clk_out_c}, 2'b10);
      gen_clk = 1'b0; #1;
      check("R9 code10 low", {clk_out_b, clk_out_c}, 2'b01);
      wr_cfg(C_EN | 32'h0300_0000); osc_clk = 1'b1; gen_clk = 1'b1; #1;
      check("R9 code11", {clk_out_b, clk_out_c}, 2'b11);
      osc_clk = 1'b0; #1;
      check("R9 code11 osc low", {clk_out_b, clk_out_c}, 2'b10);
      wr_cfg(C_EN); #1;
      check("R9 code00", {clk_out_b, clk_out_c}, 2'b00);
   endtask

   task automatic t_pin_a();
      do_reset();
      pll_rec_clk = 1'b1; syn_rec_clk = 1'b1;
      wr_cfg(32'h0040_0000); #1;
      check("R10 code01", clk_out_a, 0);
      wr_cfg(32'h0080_0000); syn_rec_clk = 1'b0; #1;
      check("R10 code10", clk_out_a, 1);
      wr_cfg(32'h00C0_0000); #1;
      check("R10 code11 low", clk_out_a, 0);
      syn_rec_clk = 1'b1; #1;
      check("R10 code11 high", clk_out_a, 1);
   endtask

   task automatic t_framing();
      do_reset();
      store_sel = 1'b0; tx_byte = 8'hC3;
      wr_cfg(C_EN);
      send_byte(8'h81);
      check("R11 rx_stb", rx_stb, 1);
      check("R11 rx_byte", rx_byte, 8'h81);
      check("R11 sw write", {swc_wr_en, bfc_wr_en}, 2'b10);
      check("R11 sw data", swc_wr_data, 8'h81);
      send_byte(8'h00);
      check("R11 tx order", tx_cap, 8'hC3);
      check("R11 strobe one cycle", rx_stb, 1);
      @(negedge clk);
      check("R11 strobe drops", rx_stb, 0);
   endtask

   task automatic t_idle();
      do_reset();
      send_byte(8'hFF);
      check("R12 no byte", rx_stb, 0);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      check("R12 no byte partial", rx_stb, 0);
      wr_cfg(C_EN);
      send_byte(8'h4B);
      check("R12 count held", rx_stb, 1);
      check("R12 byte intact", rx_byte, 8'h4B);
   endtask

   task automatic t_pin_loop();
      do_reset();
      wr_cfg(C_PIN | C_EN);
      ser_rx_pin = 1'b1; #1;
      check("R2 high", ser_tx_pin, 1);
      ser_rx_pin = 1'b0; #1;
      check("R2 low", ser_tx_pin, 0);
   endtask

   task automatic t_rx_from_tx();
      do_reset();
      tx_byte = 8'hA5;
      wr_cfg(C_RXTX | C_EN);
      send_byte(8'hFF);
      check("R3 rx pin ignored", rx_byte, 8'h00);
      send_byte(8'h00);
      check("R3 rx from tx", rx_byte, 8'hA5);
   endtask

   task automatic t_byte_loop();
      do_reset();
      tx_byte = 8'h00;
      wr_cfg(C_BYTE | C_EN);
      send_byte(8'h3C);
      send_byte(8'h96);
      check("R4 first replay", tx_cap, 8'h3C);
      send_byte(8'h00);
      check("R4 second replay", tx_cap, 8'h96);
   endtask

   task automatic t_priority();
      do_reset();
      wr_cfg(C_PIN | C_BYTE | C_EN);
      send_byte(8'h5A);
      send_byte(8'h0F);
      check("R5 pin over byte", tx_cap, 8'h0F);
   endtask

   task automatic t_store();
      do_reset();
      swc_rd_data = 8'h11; bfc_rd_data = 8'h5A; store_sel = 1'b1;
      wr_cfg(C_STORE | C_EN);
      send_byte(8'h77);
      check("R6 buf only", {swc_wr_en, bfc_wr_en}, 2'b01);
      check("R6 buf data", bfc_wr_data, 8'h5A);
      store_sel = 1'b0;
      send_byte(8'h77);
      check("R6 sw only", {swc_wr_en, bfc_wr_en}, 2'b10);
      check("R6 sw data", swc_wr_data, 8'h11);
   endtask

   task automatic t_par();
      do_reset();
      wr_cfg(C_PAR | C_EN);
      swc_rd_data = 8'hE1; bfc_rd_data = 8'h1E; #1;
      check("R7 sw", swc_wr_data, 8'hE1);
      check("R7 buf", bfc_wr_data, 8'h1E);
      swc_rd_data = 8'h3D; bfc_rd_data = 8'hC2; #1;
      check("R7 sw follows", swc_wr_data, 8'h3D);
      check("R7 buf follows", bfc_wr_data, 8'hC2);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_gate();
      t_pin_bc();
      t_pin_a();
      t_framing();
      t_idle();
      t_pin_loop();
      t_rx_from_tx();
      t_byte_loop();
      t_priority();
      t_store();
      t_par();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule